// File: doc/BRIEF.md
# Manchester Bitstream Receiver with Frame Lock

This block takes a Manchester-coded serial line from an external modulator and recovers its data. The modulator runs on its own clock, which has no fixed relation to the local clock. The receiver samples the line with the local clock through a two-flop synchronizer and looks for edges. It follows the bit cell from the transition in the middle of each cell and ignores the transitions that fall on cell boundaries. Because every cell carries a transition, the line has no DC content, so it can cross capacitive, transformer or optical isolation.

The recovered bits form three-bit frames. Each frame starts with a fixed sync bit, followed by one bit for modulator stream A and one bit for stream B. The receiver reports lock after a run of correct sync bits. While locked, it passes the stream bits to the downstream filters with one valid strobe per bit. It also gives a strobe for every correct sync bit, which software can count to compare the external clock rate with the local one. A low channel enable holds the whole receiver idle.

Top module: `manch_rx`

## Requirements
- R1: During and right after synchronous reset, every output is low.
- R2: A bit is read from the transition in the middle of its cell. A rising transition (line low in the first half, high in the second) decodes as 1, and a falling transition decodes as 0. Every stream bit is delivered, in order and with its correct value, on its stream's output.
- R3: Transitions on cell boundaries are ignored. With OVS=8, a mid-cell transition is accepted 7 to 11 local clocks after the previous one, so cells of 7 and of 10 clocks both decode correctly. Two bits are never accepted on adjacent clocks.
- R4: A frame is the sync bit (value 1), then the stream-A bit, then the stream-B bit. `a_vld_o` and `b_vld_o` pulse only while `locked_o` is high, and at most one strobe output is high in any cycle.
- R5: `locked_o` rises when the 8th consecutive correct sync bit is decoded, and not before. The stream bits of that frame are already delivered.
- R6: A wrong sync bit clears `locked_o`, and no stream strobes follow until lock is regained.
- R7: If no mid-cell transition arrives within the accept window (11 clocks at OVS=8), `locked_o` clears and bit tracking restarts.
- R8: While `en_i` is low, the receiver shows no lock and raises no strobes, whatever the line does. Lowering `en_i` clears lock on the next clock.
- R9: `sync_stb_o` pulses once for every sync bit with the correct value that is decoded in the sync position of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Channel enable |
| line_i | input | 1 | Manchester line, asynchronous to clk |
| a_bit_o | output | 1 | Stream-A data bit |
| a_vld_o | output | 1 | Stream-A bit valid strobe |
| b_bit_o | output | 1 | Stream-B data bit |
| b_vld_o | output | 1 | Stream-B bit valid strobe |
| locked_o | output | 1 | Frame sync achieved; stream bits are valid |
| sync_stb_o | output | 1 | Pulse for each correct sync bit |

## Verification
A wrong cell phase shows up within one cell: a boundary edge is taken for a data bit, or a mid edge is missed. The result is a wrong bit value on a stream output, or a lock that drops about 11 clocks later. A wrong frame slot shows up within one frame as stream bits that swap between A and B, or as a wrong-sync drop. A bad lock counter shows up as `locked_o` rising one frame too early or too late. The bench models every frame with queues and checks each strobe as it appears, so any of these faults is seen in the cycle it reaches the ports.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic [1:0] {
    SLOT_SYNC = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } slot_e;
endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  // STAGES flops for metastability, one more to detect the edge
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/mrx_cell.sv
module mrx_cell #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rise,
  input  logic fall,
  output logic bit_vld_o,
  output logic bit_o,
  output logic miss_o
);
  localparam int WIN_LO = (OVS * 3) / 4;
  localparam int WIN_HI = (OVS * 5) / 4;
  localparam int PW     = $clog2(WIN_HI + 1);

  logic [PW-1:0] ph_q;
  logic          track_q;
  logic          edge_w, accept_w, miss_w;

  assign edge_w   = rise | fall;
  // Before tracking starts, take the first edge as a mid-cell edge.
  assign accept_w = edge_w && (!track_q || ph_q >= PW'(WIN_LO));
  assign miss_w   = track_q && !edge_w && ph_q >= PW'(WIN_HI);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q      <= '0;
      track_q   <= 1'b0;
      bit_vld_o <= 1'b0;
      bit_o     <= 1'b0;
      miss_o    <= 1'b0;
    end else begin
      bit_vld_o <= accept_w;
      miss_o    <= miss_w;
      if (accept_w) bit_o <= rise;
      if (accept_w) begin
        track_q <= 1'b1;
        ph_q    <= '0;
      end else if (miss_w) begin
        track_q <= 1'b0;
        ph_q    <= '0;
      end else if (track_q) begin
        ph_q    <= ph_q + 1'b1;
      end
    end
  end

  AST_BIT_SPACING: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |=> !bit_vld_o); // R3
  AST_MISS_NOT_BIT: assert property (@(posedge clk) disable iff (rst)
    !(bit_vld_o && miss_o)); // R7
endmodule

// File: rtl/mrx_frame.sv
module mrx_frame
  import mrx_pkg::*;
#(
  parameter int   LOCK_CNT = 8,
  parameter logic SYNC_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic miss,
  output logic a_bit_o,
  output logic a_vld_o,
  output logic b_bit_o,
  output logic b_vld_o,
  output logic locked_o,
  output logic sync_stb_o
);
  localparam int CW = $clog2(LOCK_CNT + 1);

  slot_e         slot_q;
  logic [CW-1:0] good_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      slot_q     <= SLOT_SYNC;
      good_q     <= '0;
      locked_o   <= 1'b0;
      a_bit_o    <= 1'b0;
      a_vld_o    <= 1'b0;
      b_bit_o    <= 1'b0;
      b_vld_o    <= 1'b0;
      sync_stb_o <= 1'b0;
    end else begin
      a_vld_o    <= 1'b0;
      b_vld_o    <= 1'b0;
      sync_stb_o <= 1'b0;
      if (miss) begin
        locked_o <= 1'b0;
        good_q   <= '0;
        slot_q   <= SLOT_SYNC;
      end else if (bit_vld) begin
        case (slot_q)
          SLOT_SYNC: begin
            if (bit_in == SYNC_VAL) begin
              sync_stb_o <= 1'b1;
              slot_q     <= SLOT_A;
              if (good_q != CW'(LOCK_CNT)) good_q <= good_q + 1'b1;
              if (good_q >= CW'(LOCK_CNT - 1)) locked_o <= 1'b1;
            end else begin
              // stay in the sync slot: this slips the frame by one bit
              good_q   <= '0;
              locked_o <= 1'b0;
            end
          end
          SLOT_A: begin
            slot_q <= SLOT_B;
            if (locked_o) begin
              a_vld_o <= 1'b1;
              a_bit_o <= bit_in;
            end
          end
          SLOT_B: begin
            slot_q <= SLOT_SYNC;
            if (locked_o) begin
              b_vld_o <= 1'b1;
              b_bit_o <= bit_in;
            end
          end
          default: slot_q <= SLOT_SYNC;
        endcase
      end
    end
  end

  AST_STREAM_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (a_vld_o || b_vld_o) |-> locked_o); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_vld_o, b_vld_o, sync_stb_o})); // R4
  AST_LOCK_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> sync_stb_o); // R5
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (rst)
    miss |=> !locked_o); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(locked_o || a_vld_o || b_vld_o || sync_stb_o)); // R8
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int   OVS         = 8,
  parameter int   SYNC_STAGES = 2,
  parameter int   LOCK_CNT    = 8,
  parameter logic SYNC_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic line_i,
  output logic a_bit_o,
  output logic a_vld_o,
  output logic b_bit_o,
  output logic b_vld_o,
  output logic locked_o,
  output logic sync_stb_o
);
  logic rise_w, fall_w;
  logic bit_vld_w, bit_w, miss_w;

  mrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .din    (line_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  mrx_cell #(.OVS(OVS)) u_cell (
    .clk       (clk),
    .rst       (rst),
    .en        (en_i),
    .rise      (rise_w),
    .fall      (fall_w),
    .bit_vld_o (bit_vld_w),
    .bit_o     (bit_w),
    .miss_o    (miss_w)
  );

  mrx_frame #(.LOCK_CNT(LOCK_CNT), .SYNC_VAL(SYNC_VAL)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .en         (en_i),
    .bit_vld    (bit_vld_w),
    .bit_in     (bit_w),
    .miss       (miss_w),
    .a_bit_o    (a_bit_o),
    .a_vld_o    (a_vld_o),
    .b_bit_o    (b_bit_o),
    .b_vld_o    (b_vld_o),
    .locked_o   (locked_o),
    .sync_stb_o (sync_stb_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !(locked_o || a_vld_o || b_vld_o || sync_stb_o)); // R1
endmodule

// File: tb/test_manch_rx.sv
`timescale 1ns/1ps
module test_manch_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0;
  logic line_i = 1'b0;
  logic a_bit_o, a_vld_o, b_bit_o, b_vld_o, locked_o, sync_stb_o;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  bit done = 1'b0;
  bit qa[$];
  bit qb[$];

  always #2 clk = ~clk;

  manch_rx i_manch_rx (
    .clk(clk), .rst(rst), .en_i(en_i), .line_i(line_i),
    .a_bit_o(a_bit_o), .a_vld_o(a_vld_o), .b_bit_o(b_bit_o), .b_vld_o(b_vld_o),
    .locked_o(locked_o), .sync_stb_o(sync_stb_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: every stream strobe is compared with the queued frame bits
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (a_vld_o) begin
        if (qa.size() == 0) chk(1'b0, "R4 unexpected A strobe", 1, 0);
        else begin
          bit e;
          e = qa.pop_front();
          chk(a_bit_o == e, "R2 stream A bit", int'(a_bit_o), int'(e));
        end
      end
      if (b_vld_o) begin
        if (qb.size() == 0) chk(1'b0, "R4 unexpected B strobe", 1, 0);
        else begin
          bit e;
          e = qb.pop_front();
          chk(b_bit_o == e, "R2 stream B bit", int'(b_bit_o), int'(e));
        end
      end
      if (sync_stb_o) stb_cnt++;
    end
  end

  task automatic drive_bit(input bit b, input int h1, input int h2);
    line_i = ~b;
    repeat (h1) @(negedge clk);
    line_i = b;
    repeat (h2) @(negedge clk);
  endtask

  task automatic send_frame(input bit s, input bit a, input bit b,
                            input bit expect_out, input int h1, input int h2);
    if (expect_out) begin
      qa.push_back(a);
      qb.push_back(b);
    end
    drive_bit(s, h1, h2);
    drive_bit(a, h1, h2);
    drive_bit(b, h1, h2);
  endtask

  task automatic rand_frames(input int n, input bit expect_out);
    for (int i = 0; i < n; i++)
      send_frame(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 expect_out, 4, 4);
  endtask

  task automatic idle_low(input int n);
    line_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Fresh lock: 7 frames that produce nothing, then the locking frame onward
  task automatic relock;
    idle_low(20);
    rand_frames(7, 1'b0);
    rand_frames(1, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!(locked_o || a_vld_o || b_vld_o || sync_stb_o), "R1 outputs in reset",
        int'({locked_o, a_vld_o, b_vld_o, sync_stb_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!(locked_o || a_vld_o || b_vld_o || sync_stb_o), "R1 outputs after reset",
        int'({locked_o, a_vld_o, b_vld_o, sync_stb_o}), 0);

    // R8: channel disabled, line active
    rand_frames(12, 1'b0);
    chk(locked_o == 1'b0, "R8 no lock while disabled", int'(locked_o), 0);
    chk(stb_cnt == 0, "R8 no sync strobes while disabled", stb_cnt, 0);

    // R5: lock after exactly 8 correct sync bits
    idle_low(4);
    en_i = 1'b1;
    idle_low(4);
    stb_cnt = 0;
    rand_frames(7, 1'b0);
    chk(locked_o == 1'b0, "R5 not locked after 7 sync bits", int'(locked_o), 0);
    rand_frames(1, 1'b1);
    chk(locked_o == 1'b1, "R5 locked after 8 sync bits", int'(locked_o), 1);
    rand_frames(20, 1'b1);
    repeat (2) @(negedge clk);
    chk(stb_cnt == 28, "R9 one strobe per sync bit", stb_cnt, 28);

    // R3: slow and fast external clock, boundary edges ignored
    for (int i = 0; i < 8; i++)
      send_frame(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 5, 5);
    chk(locked_o == 1'b1, "R3 lock kept with 10-clock cells", int'(locked_o), 1);
    for (int i = 0; i < 8; i++)
      send_frame(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b1, 4, 3);
    chk(locked_o == 1'b1, "R3 lock kept with 7-clock cells", int'(locked_o), 1);
    send_frame(1'b1, 1'b0, 1'b0, 1'b1, 4, 4);
    send_frame(1'b1, 1'b1, 1'b1, 1'b1, 4, 4);
    send_frame(1'b1, 1'b1, 1'b0, 1'b1, 4, 4);
    send_frame(1'b1, 1'b0, 1'b1, 1'b1, 4, 4);
    repeat (2) @(negedge clk);
    chk(qa.size() == 0 && qb.size() == 0, "R2 all stream bits delivered",
        qa.size() + qb.size(), 0);

    // R6: wrong sync bit drops lock, no stream bits follow
    send_frame(1'b0, 1'b0, 1'b0, 1'b0, 4, 4);
    chk(locked_o == 1'b0, "R6 lock cleared by wrong sync", int'(locked_o), 0);
    send_frame(1'b1, 1'b1, 1'b0, 1'b0, 4, 4);
    chk(locked_o == 1'b0, "R6 still unlocked one frame later", int'(locked_o), 0);

    // R7: missing mid-cell transition drops lock
    relock;
    rand_frames(3, 1'b1);
    repeat (2) @(negedge clk);
    chk(locked_o == 1'b1, "R7 locked before line stall", int'(locked_o), 1);
    repeat (16) @(negedge clk);
    chk(locked_o == 1'b0, "R7 lock cleared after stall", int'(locked_o), 0);

    // R8: disable while locked
    relock;
    rand_frames(3, 1'b1);
    repeat (2) @(negedge clk);
    chk(locked_o == 1'b1, "R8 locked before disable", int'(locked_o), 1);
    en_i = 1'b0;
    @(negedge clk);
    chk(locked_o == 1'b0, "R8 lock cleared one clock after disable", int'(locked_o), 0);
    stb_cnt = 0;
    rand_frames(5, 1'b0);
    chk(stb_cnt == 0 && locked_o == 1'b0, "R8 quiet while disabled", stb_cnt, 0);
    chk(qa.size() == 0 && qb.size() == 0, "R2 queues empty at end",
        qa.size() + qb.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule